// File: doc/BRIEF.md
# Interrupt Moderation Timer Unit

This unit limits how often interrupts leave a group of sources. A shared two-stage prescaler turns the clock into a moderation tick. A fixed base divider sets the base tick. A programmable resolution value N then passes one tick out of every N+1 base ticks. Each lane has an 8-bit down-counting timer that counts these ticks. There are `NUM_VEC` message-style vector lanes and one legacy group lane, and the legacy lane has its own interval register.

A request on an idle lane fires at once and loads the lane's timer from its interval. A request that arrives while the timer is running is held. The held request fires once, in the cycle after the timer reaches zero, and the timer reloads. An interval of zero turns moderation off for that lane. A flush strobe releases every held request on the next cycle and clears all timers. Software programs the resolution and the intervals through a simple register write port.

Top module: `intr_moderator`

## Requirements
- R1: With resolution N and base divider `BASE_DIV`, a running lane timer decrements once every (N+1)*`BASE_DIV` clock cycles. The prescaler runs freely from reset.
- R2: The write port is decoded as follows. Address 0 holds the resolution. Address 1+k holds the interval of vector k, for k from 0 to `NUM_VEC`-1. Address `NUM_VEC`+1 holds the legacy interval. A write to any other address has no effect on behaviour.
- R3: A lane whose interval is 0 and whose timer is 0 raises its fire output in the cycle after each cycle in which its request is high.
- R4: A request on a lane whose timer is 0 raises fire for exactly one cycle, after the next clock edge, and loads the timer with the lane's interval. Requests that arrive while the timer is nonzero produce no fire until the timer expires.
- R5: When the timer of a lane with a held request reaches 0, the lane fires one pulse on the following edge, clears the held state and reloads the timer. Any number of held requests yields a single pulse.
- R6: A write to an interval takes effect at the next reload and does not alter a countdown already in progress.
- R7: A flush makes every lane that has a held request, or a request in the flush cycle, fire after the next edge. It clears all timers and held state, so the next request fires at once.
- R8: The legacy lane (request `legacy_req_i`, output `legacy_fire_o`) moderates by its own interval with the shared resolution, independently of the vector lanes.
- R9: While `rst_ni` is low, all fire outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | 8 | Register write data |
| req_i | input | NUM_VEC | Per-vector interrupt requests |
| legacy_req_i | input | 1 | Legacy group interrupt request |
| flush_i | input | 1 | Moderation flush strobe |
| fire_o | output | NUM_VEC | Per-vector fire pulses |
| legacy_fire_o | output | 1 | Legacy fire pulse |

## Verification
Wrong internal state in this block shows up only in the timing of fire pulses. A prescaler count that is off by one moves every held fire by one tick period, so the error becomes visible a full (N+1)*`BASE_DIV`*interval cycles later. A held flag that is stuck or lost shows up either as an extra pulse or as a missing pulse when the timer expires. A timer that is not cleared by a flush shows up on the first request after the flush, which fails to fire on the next cycle. For this reason the bench compares every fire output against a cycle model on every cycle, and it lets runs continue long enough to cover several complete intervals.

// File: rtl/intr_mod_pkg.sv
package intr_mod_pkg;
  localparam int unsigned INTV_W = 8;
  localparam int unsigned RES_W  = 8;
  typedef logic [INTV_W-1:0] intv_t;
  typedef logic [RES_W-1:0]  res_t;
endpackage

// File: rtl/intr_mod_prescaler.sv
module intr_mod_prescaler
  import intr_mod_pkg::*;
#(
  parameter int unsigned BASE_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  res_t res_i,
  output logic tick_o
);
  localparam int unsigned BW = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
  localparam logic [BW-1:0] BMAX = BW'(BASE_DIV - 1);

  logic [BW-1:0] base_q;
  res_t          rcnt_q;
  logic          base_tick;

  assign base_tick = (base_q == BMAX);
  assign tick_o    = base_tick && (rcnt_q >= res_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      rcnt_q <= '0;
    end else begin
      base_q <= base_tick ? '0 : base_q + 1'b1;
      if (base_tick) rcnt_q <= (rcnt_q >= res_i) ? '0 : rcnt_q + 1'b1;
    end
  end

  generate
    if (BASE_DIV > 1) begin : g_spacing
      a_r1_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/intr_mod_lane.sv
module intr_mod_lane
  import intr_mod_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  input  logic  intv_we_i,
  input  intv_t intv_i,
  input  logic  req_i,
  input  logic  flush_i,
  output logic  fire_o
);
  intv_t intv_q, timer_q;
  logic  held_q, fire_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      intv_q  <= '0;
      timer_q <= '0;
      held_q  <= 1'b0;
      fire_q  <= 1'b0;
    end else begin
      if (intv_we_i) intv_q <= intv_i;
      if (flush_i) begin
        fire_q  <= held_q | req_i;
        timer_q <= '0;
        held_q  <= 1'b0;
      end else if (timer_q == '0) begin
        fire_q <= held_q | req_i;
        if (held_q | req_i) begin
          timer_q <= intv_q;  // reload uses value before any same-cycle write
          held_q  <= 1'b0;
        end
      end else begin
        fire_q <= 1'b0;
        if (req_i) held_q <= 1'b1;
        if (tick_i) timer_q <= timer_q - 1'b1;
      end
    end
  end

  assign fire_o = fire_q;

  a_r3_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (intv_q == '0 && timer_q == '0 && req_i) |=> fire_q);
  a_r4_quiet_while_counting: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timer_q != '0 && !flush_i) |=> !fire_q);
  a_r6_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timer_q == '0 && !flush_i && (req_i || held_q)) |=> (fire_q && timer_q == $past(intv_q)));
  a_r7_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (timer_q == '0 && !held_q));
endmodule

// File: rtl/intr_moderator.sv
module intr_moderator
  import intr_mod_pkg::*;
#(
  parameter int unsigned NUM_VEC  = 4,
  parameter int unsigned BASE_DIV = 4,
  localparam int unsigned LANES   = NUM_VEC + 1,
  localparam int unsigned ADDR_W  = $clog2(NUM_VEC + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [NUM_VEC-1:0] req_i,
  input  logic              legacy_req_i,
  input  logic              flush_i,
  output logic [NUM_VEC-1:0] fire_o,
  output logic              legacy_fire_o
);
  res_t             res_q;
  logic             tick;
  logic [LANES-1:0] lane_req, lane_fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_q <= '0;
    else if (wr_en_i && wr_addr_i == '0) res_q <= res_t'(wr_data_i);
  end

  intr_mod_prescaler #(.BASE_DIV(BASE_DIV)) i_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .res_i (res_q),
    .tick_o(tick)
  );

  assign lane_req = {legacy_req_i, req_i};

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic we;
    assign we = wr_en_i && (32'(wr_addr_i) == k + 1);
    intr_mod_lane i_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick),
      .intv_we_i(we),
      .intv_i   (intv_t'(wr_data_i)),
      .req_i    (lane_req[k]),
      .flush_i  (flush_i),
      .fire_o   (lane_fire[k])
    );
  end

  assign fire_o        = lane_fire[NUM_VEC-1:0];
  assign legacy_fire_o = lane_fire[NUM_VEC];

  a_r9_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (lane_fire == '0));
endmodule

// File: tb/test_intr_moderator.sv
module test_intr_moderator;
  localparam int NV = 4;
  localparam int BD = 4;
  localparam int LN = NV + 1;
  localparam int AW = $clog2(NV + 2);

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic [NV-1:0] req = '0;
  logic          lreq = 1'b0, flush = 1'b0;
  logic [NV-1:0] fire;
  logic          lfire;

  always #4 clk = ~clk;

  intr_moderator #(.NUM_VEC(NV), .BASE_DIV(BD)) i_intr_moderator (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .req_i(req), .legacy_req_i(lreq), .flush_i(flush),
    .fire_o(fire), .legacy_fire_o(lfire)
  );

  int n_chk = 0, n_bad = 0;
  string tag = "R9";
  int m_tim[LN], m_intv[LN];
  bit m_held[LN], m_fire[LN];
  int m_base = 0, m_rcnt = 0, m_res = 0;
  int fire_cnt[LN];

  function automatic logic [LN-1:0] model_vec();
    logic [LN-1:0] v;
    for (int k = 0; k < LN; k++) v[k] = m_fire[k];
    return v;
  endfunction

  function automatic void model_edge(bit we, int a, int d, logic [LN-1:0] rq, bit fl);
    bit bt = (m_base == BD-1);
    bit tk = bt && (m_rcnt >= m_res);
    for (int k = 0; k < LN; k++) begin
      if (fl) begin
        m_fire[k] = m_held[k] | rq[k]; m_tim[k] = 0; m_held[k] = 0;
      end else if (m_tim[k] == 0) begin
        m_fire[k] = m_held[k] | rq[k];
        if (m_fire[k]) begin m_tim[k] = m_intv[k]; m_held[k] = 0; end
      end else begin
        m_fire[k] = 0;
        if (rq[k]) m_held[k] = 1;
        if (tk) m_tim[k] = m_tim[k] - 1;
      end
    end
    if (bt) m_rcnt = (m_rcnt >= m_res) ? 0 : m_rcnt + 1;
    m_base = bt ? 0 : m_base + 1;
    if (we) begin
      if (a == 0) m_res = d;
      else if (a <= LN) m_intv[a-1] = d;
    end
  endfunction

  task automatic check_out();
    logic [LN-1:0] got = {lfire, fire};
    logic [LN-1:0] exp = model_vec();
    n_chk++;
    for (int k = 0; k < LN; k++) fire_cnt[k] += got[k];
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: fire got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(bit we, int a, int d, logic [LN-1:0] rq, bit fl);
    wr_en = we; wr_addr = AW'(a); wr_data = 8'(d);
    req = rq[NV-1:0]; lreq = rq[NV]; flush = fl;
    @(posedge clk);
    model_edge(we, a, d, rq, fl);
    @(negedge clk);
    wr_en = 0; req = '0; lreq = 0; flush = 0;
    check_out();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, '0, 0);
  endtask

  task automatic clr_cnt();
    for (int k = 0; k < LN; k++) fire_cnt[k] = 0;
  endtask

  task automatic expect_cnt(int k, int e);
    n_chk++;
    if (fire_cnt[k] != e) begin
      n_bad++;
      $display("FAIL %s: lane %0d pulses got %0d expected %0d", tag, k, fire_cnt[k], e);
    end
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed = 32'h5eed_1234;
    void'($urandom(seed));
    for (int k = 0; k < LN; k++) begin
      m_tim[k] = 0; m_intv[k] = 0; m_held[k] = 0; m_fire[k] = 0;
    end
    clr_cnt();
    tag = "R9";
    repeat (3) @(negedge clk);
    check_out();
    rst_n = 1'b1;

    tag = "R3";
    step(0, 0, 0, 5'b00001, 0);
    step(0, 0, 0, 5'b00001, 0);
    step(0, 0, 0, 5'b00011, 0);

    tag = "R2";
    step(1, 0, 1, '0, 0);
    step(1, 1, 3, '0, 0);
    step(1, 2, 1, '0, 0);
    step(1, LN, 2, '0, 0);
    step(1, 7, 9, '0, 0);

    tag = "R4";
    clr_cnt();
    step(0, 0, 0, 5'b00001, 0);
    for (int i = 0; i < 10; i++) step(0, 0, 0, 5'b00001, 0);
    expect_cnt(0, 1);

    tag = "R5";
    clr_cnt();
    idle(40);
    expect_cnt(0, 1);

    tag = "R1";
    clr_cnt();
    for (int i = 0; i < 96; i++) step(0, 0, 0, 5'b00010, 0);
    idle(20);

    tag = "R6";
    step(0, 0, 0, 5'b00001, 0);
    step(1, 1, 6, 5'b00001, 0);
    idle(60);

    tag = "R8";
    for (int i = 0; i < 60; i++) step(0, 0, 0, 5'b10001, 0);
    idle(30);

    tag = "R7";
    step(0, 0, 0, 5'b11111, 0);
    step(0, 0, 0, 5'b11111, 0);
    step(0, 0, 0, '0, 1);
    step(0, 0, 0, 5'b00001, 0);
    step(0, 0, 0, 5'b00100, 1);
    idle(5);

    tag = "R5";
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 3) step(1, $urandom_range(0, 7), $urandom_range(0, 5), '0, 0);
      else if (r < 5) step(0, 0, 0, LN'($urandom), 1);
      else step(0, 0, 0, LN'($urandom) & LN'($urandom), 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule